// File: doc/BRIEF.md
# Coherence-Aware Line Replica Cache

This block is a small, fully associative side store that sits beside a private second-level cache. It keeps spare copies of lines that were recently written or shared in that cache, so that when a line in the main array is found to be hit by a multi-bit soft error, a clean copy can be fetched here and written back into the array. The block learns what to keep from a stream of coherence events. Each event carries a code, a line address and the full line data.

Every entry holds a tag, the line data, an age and its own coherence state. The states are modified, shared, exclusive, invalid and an extra "stale" state. An entry goes stale when a remote write invalidates its line; the line is likely to be written again soon. Allocation reuses an entry that already matches the address, otherwise the lowest-numbered free entry, otherwise the oldest entry. An overwritten entry is dropped silently, even when it is modified, because the block has no path to the next level. A separate combinational lookup port answers whether a usable copy of an address is held, and returns that copy.

Top module: `replica_cache`

## Requirements
- R1: After reset every entry is invalid. A lookup of any address reports no hit and state I (code 0). `evReady` is 1 from the first cycle after reset is released.
- R2: An event with code 1 (an L1 eviction written into L2) or code 2 (an L2 write that makes the line modified) stores the line and its data with state M (code 3).
- R3: An event with code 3 (a shared read miss) or code 4 (a probe read hit) stores the line and its data with state S (code 1).
- R4: An event with code 5 (the line becomes exclusive) refreshes the data of a matching entry and sets it to state E (code 2). If no entry matches, nothing is allocated and no entry changes.
- R5: An event with code 6 (a probe write hit or remote invalidation) moves a matching entry to state N (code 4). The lookup then reports no hit and state N. A later allocation of the same address reuses that entry, so no other entry is displaced.
- R6: An event with code 7 (L2 victim replacement) sets a matching entry to state I.
- R7: An event with code 0 (a local read hit in L2) changes no entry state, data or age.
- R8: An allocation that matches no entry takes a free (I) entry before it evicts any valid entry.
- R9: When no entry is free, an allocation overwrites the entry that was least recently allocated or refreshed. Allocation and exclusive refresh both make an entry the youngest.
- R10: The lookup port reports a hit only for an entry in state M, S or E. It returns that entry's state and data in the same cycle. It reflects an accepted event from the next cycle on.
- R11: One event is accepted on every cycle in which `evValid` and `evReady` are both high, including back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evValid | input | 1 | Event present |
| evReady | output | 1 | Event can be accepted |
| evCode | input | 3 | Event code (0 to 7) |
| evAddr | input | ADDR_W | Line address of the event |
| evData | input | LINE_W | Line data carried by the event |
| lkAddr | input | ADDR_W | Recovery lookup address |
| lkHit | output | 1 | Usable copy held (M, S or E) |
| lkState | output | 3 | State of the matching entry, or I |
| lkData | output | LINE_W | Data of the matching entry |

## Verification
The hardest situation to reach from the ports is a full store in which the age order is no longer the insertion order. The bench inserts 128 distinct lines back to back, then refreshes the oldest line through an exclusive event, so the next allocation has to skip it. It then frees one entry through a victim event, to show that a free slot wins over the oldest valid one. Finally it makes an entry stale and then reallocates the same address, to show that the stale entry is reused rather than the oldest entry being evicted.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic [2:0] {
    EV_RD_HIT = 3'd0, EV_L1_WB = 3'd1, EV_L2_WR = 3'd2, EV_SH_MISS = 3'd3,
    EV_PRB_RD = 3'd4, EV_EXCL = 3'd5, EV_PRB_WR = 3'd6, EV_VICTIM = 3'd7
  } evCodeT;

  typedef enum logic [2:0] {
    ST_I = 3'd0, ST_S = 3'd1, ST_E = 3'd2, ST_M = 3'd3, ST_N = 3'd4
  } lineStateT;

  typedef struct packed {
    logic      wr;
    logic      ld;
    logic      touch;
    lineStateT nextState;
  } strobeT;
endpackage

// File: rtl/rc_ctrl.sv
module rc_ctrl
  import rc_pkg::*;
#(
  parameter int ENTRIES = 128,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     evFire,
  input  logic [2:0]               evCode,
  input  logic [ENTRIES-1:0]       matchVec,
  input  logic [ENTRIES-1:0]       oldVec,
  input  logic [ENTRIES-1:0][2:0]  stateVec,
  output strobeT                   stb,
  output logic [IDX_W-1:0]         stbIdx
);
  logic [ENTRIES-1:0] freeVec;
  logic [IDX_W-1:0]   hitIdx, freeIdx, lruIdx;
  logic               anyMatch, anyFree, isAlloc;

  always_comb begin
    hitIdx  = '0;
    freeIdx = '0;
    lruIdx  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      freeVec[i] = (stateVec[i] == ST_I);
      if (matchVec[i]) hitIdx = IDX_W'(i);
      if (oldVec[i])   lruIdx = IDX_W'(i);
    end
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (freeVec[i]) freeIdx = IDX_W'(i);
    end
    anyMatch = |matchVec;
    anyFree  = |freeVec;
  end

  always_comb begin
    stb     = '{wr: 1'b0, ld: 1'b0, touch: 1'b0, nextState: ST_I};
    isAlloc = 1'b0;
    stbIdx  = hitIdx;
    if (evFire) begin
      unique case (evCode)
        EV_L1_WB, EV_L2_WR: begin isAlloc = 1'b1; stb.nextState = ST_M; end
        EV_SH_MISS, EV_PRB_RD: begin isAlloc = 1'b1; stb.nextState = ST_S; end
        EV_EXCL: if (anyMatch) stb = '{wr: 1'b1, ld: 1'b1, touch: 1'b1, nextState: ST_E};
        EV_PRB_WR: if (anyMatch) stb = '{wr: 1'b1, ld: 1'b0, touch: 1'b0, nextState: ST_N};
        EV_VICTIM: if (anyMatch) stb = '{wr: 1'b1, ld: 1'b0, touch: 1'b0, nextState: ST_I};
        default: ;
      endcase
      if (isAlloc) begin
        stb.wr    = 1'b1;
        stb.ld    = 1'b1;
        stb.touch = 1'b1;
        stbIdx    = anyMatch ? hitIdx : (anyFree ? freeIdx : lruIdx);
      end
    end
  end

  // R8
  free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (isAlloc && !anyMatch && anyFree) |-> (stateVec[stbIdx] == ST_I));
endmodule

// File: rtl/rc_store.sv
module rc_store
  import rc_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter int ADDR_W  = 32,
  parameter int LINE_W  = 512,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int AGE_W = $clog2(ENTRIES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  strobeT                   stb,
  input  logic [IDX_W-1:0]         stbIdx,
  input  logic [ADDR_W-1:0]        evAddr,
  input  logic [LINE_W-1:0]        evData,
  input  logic [ADDR_W-1:0]        lkAddr,
  output logic [ENTRIES-1:0]       matchVec,
  output logic [ENTRIES-1:0]       oldVec,
  output logic [ENTRIES-1:0][2:0]  stateVec,
  output logic                     lkHit,
  output logic [2:0]               lkState,
  output logic [LINE_W-1:0]        lkData
);
  logic [ADDR_W-1:0] tagArr  [ENTRIES];
  logic [LINE_W-1:0] dataArr [ENTRIES];
  logic [AGE_W-1:0]  ageArr  [ENTRIES];
  logic [ENTRIES-1:0] lkMatch;
  logic [IDX_W-1:0]   lkIdx;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign matchVec[g] = (stateVec[g] != ST_I) && (tagArr[g] == evAddr);
    assign lkMatch[g]  = (stateVec[g] != ST_I) && (tagArr[g] == lkAddr);
    assign oldVec[g]   = (ageArr[g] == AGE_W'(ENTRIES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stateVec[g] <= ST_I;
        ageArr[g]   <= AGE_W'(g);
      end else begin
        if (stb.wr && stbIdx == IDX_W'(g)) stateVec[g] <= stb.nextState;
        if (stb.touch) begin
          if (stbIdx == IDX_W'(g))              ageArr[g] <= '0;
          else if (ageArr[g] < ageArr[stbIdx])  ageArr[g] <= ageArr[g] + 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (stb.ld && stbIdx == IDX_W'(g)) begin
        tagArr[g]  <= evAddr;
        dataArr[g] <= evData;
      end
    end
  end

  always_comb begin
    lkIdx = '0;
    for (int i = 0; i < ENTRIES; i++) if (lkMatch[i]) lkIdx = IDX_W'(i);
    lkState = (|lkMatch) ? stateVec[lkIdx] : ST_I;
    lkHit   = (|lkMatch) && (lkState == ST_M || lkState == ST_S || lkState == ST_E);
    lkData  = dataArr[lkIdx];
  end

  // R5
  one_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(matchVec));

  // R9
  touch_young_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.touch |=> (ageArr[$past(stbIdx)] == '0));
endmodule

// File: rtl/replica_cache.sv
module replica_cache
  import rc_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter int ADDR_W  = 32,
  parameter int LINE_W  = 512,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evValid,
  output logic              evReady,
  input  logic [2:0]        evCode,
  input  logic [ADDR_W-1:0] evAddr,
  input  logic [LINE_W-1:0] evData,
  input  logic [ADDR_W-1:0] lkAddr,
  output logic              lkHit,
  output logic [2:0]        lkState,
  output logic [LINE_W-1:0] lkData
);
  strobeT                  stb;
  logic [IDX_W-1:0]        stbIdx;
  logic [ENTRIES-1:0]      matchVec, oldVec;
  logic [ENTRIES-1:0][2:0] stateVec;
  logic                    evFire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evReady <= 1'b0;
    else        evReady <= 1'b1;
  end
  assign evFire = evValid && evReady;

  rc_ctrl #(.ENTRIES(ENTRIES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .evFire(evFire), .evCode(evCode),
    .matchVec(matchVec), .oldVec(oldVec), .stateVec(stateVec),
    .stb(stb), .stbIdx(stbIdx));

  rc_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) store_i (
    .clk(clk), .rst_n(rst_n), .stb(stb), .stbIdx(stbIdx),
    .evAddr(evAddr), .evData(evData), .lkAddr(lkAddr),
    .matchVec(matchVec), .oldVec(oldVec), .stateVec(stateVec),
    .lkHit(lkHit), .lkState(lkState), .lkData(lkData));

  // R7
  read_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evFire && evCode == EV_RD_HIT) |=> $stable(stateVec));

  // R4
  excl_miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evFire && evCode == EV_EXCL && !(|matchVec)) |=> $stable(stateVec));
endmodule

// File: tb/replica_cache_tb.sv
module replica_cache_tb_top;
  localparam int AW = 32;
  localparam int LW = 512;

  typedef struct packed {
    logic [2:0]  code;
    logic [31:0] addr;
    logic [7:0]  salt;
    logic        expHit;
    logic [2:0]  expState;
    logic [7:0]  expSalt;
  } rowT;

  // code, addr, salt, expHit, expState, expSalt
  localparam rowT TBL [12] = '{
    '{3'd1, 32'h10, 8'd1, 1'b1, 3'd3, 8'd1},  // R2 L1 eviction -> M
    '{3'd0, 32'h10, 8'd9, 1'b1, 3'd3, 8'd1},  // R7 read hit: nothing changes
    '{3'd3, 32'h20, 8'd2, 1'b1, 3'd1, 8'd2},  // R3 shared miss -> S
    '{3'd4, 32'h10, 8'd3, 1'b1, 3'd1, 8'd3},  // R3 probe read -> S
    '{3'd5, 32'h20, 8'd4, 1'b1, 3'd2, 8'd4},  // R4 exclusive refresh -> E
    '{3'd5, 32'h30, 8'd5, 1'b0, 3'd0, 8'd0},  // R4 exclusive miss: no alloc
    '{3'd2, 32'h30, 8'd6, 1'b1, 3'd3, 8'd6},  // R2 L2 write -> M
    '{3'd6, 32'h30, 8'd7, 1'b0, 3'd4, 8'd0},  // R5 probe write -> N, no hit (R10)
    '{3'd7, 32'h20, 8'd8, 1'b0, 3'd0, 8'd0},  // R6 victim -> I
    '{3'd6, 32'h40, 8'd8, 1'b0, 3'd0, 8'd0},  // R5 probe write miss
    '{3'd7, 32'h99, 8'd8, 1'b0, 3'd0, 8'd0},  // R6 victim miss
    '{3'd2, 32'h30, 8'd8, 1'b1, 3'd3, 8'd8}   // R5 stale entry rewritten -> M
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic evValid = 1'b0, evReady;
  logic [2:0] evCode = '0;
  logic [AW-1:0] evAddr = '0, lkAddr = '0;
  logic [LW-1:0] evData = '0, lkData;
  logic lkHit;
  logic [2:0] lkState;
  int nChecks = 0, nFails = 0;
  logic finished = 1'b0;

  always #5 clk = ~clk;

  replica_cache dut_i (
    .clk(clk), .rst_n(rst_n), .evValid(evValid), .evReady(evReady),
    .evCode(evCode), .evAddr(evAddr), .evData(evData), .lkAddr(lkAddr),
    .lkHit(lkHit), .lkState(lkState), .lkData(lkData));

  function automatic logic [LW-1:0] mkLine(logic [31:0] a, logic [7:0] s);
    return {16{a ^ {s, 24'h5A3C1E}}};
  endfunction

  task automatic doReset();
    rst_n = 1'b0;
    evValid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic sendEv(logic [2:0] c, logic [31:0] a, logic [7:0] s);
    @(negedge clk);
    evValid = 1'b1; evCode = c; evAddr = a; evData = mkLine(a, s);
    @(negedge clk);
    evValid = 1'b0;
  endtask

  task automatic look(string tag, logic [31:0] a, logic eHit, logic [2:0] eSt, logic [7:0] eSalt);
    lkAddr = a;
    #1;
    nChecks++;
    if (lkHit !== eHit || lkState !== eSt || (eHit && lkData !== mkLine(a, eSalt))) begin
      nFails++;
      $display("FAIL %s addr=%h: hit=%b state=%0d data=%h expected hit=%b state=%0d data=%h",
               tag, a, lkHit, lkState, lkData[31:0], eHit, eSt, mkLine(a, eSalt) & 32'hFFFFFFFF);
    end
  endtask

  initial begin
    int bad;
    doReset();
    // R1 reset state
    nChecks++;
    if (evReady !== 1'b1) begin
      nFails++; $display("FAIL R1 evReady=%b expected 1", evReady);
    end
    look("R1", 32'h10, 1'b0, 3'd0, 8'd0);
    look("R1", 32'h0, 1'b0, 3'd0, 8'd0);

    for (int i = 0; i < 12; i++) begin
      sendEv(TBL[i].code, TBL[i].addr, TBL[i].salt);
      look($sformatf("table row %0d", i), TBL[i].addr, TBL[i].expHit, TBL[i].expState, TBL[i].expSalt);
    end

    // R8 R9 R11: fill all entries back to back
    doReset();
    for (int i = 0; i < 128; i++) begin
      evValid = 1'b1; evCode = 3'd1; evAddr = 32'h1000 + i; evData = mkLine(32'h1000 + i, 8'd1);
      @(negedge clk);
    end
    evValid = 1'b0;
    bad = 0;
    for (int i = 0; i < 128; i++) begin
      lkAddr = 32'h1000 + i;
      #1;
      if (lkHit !== 1'b1 || lkState !== 3'd3) bad++;
    end
    nChecks++;
    if (bad != 0) begin
      nFails++; $display("FAIL R11 back-to-back fill: %0d misses expected 0", bad);
    end

    sendEv(3'd5, 32'h1000, 8'd2);               // R9 refresh oldest -> youngest
    look("R4", 32'h1000, 1'b1, 3'd2, 8'd2);
    sendEv(3'd2, 32'h2000, 8'd3);               // R9 evicts 0x1001
    look("R9", 32'h1001, 1'b0, 3'd0, 8'd0);
    look("R9", 32'h1000, 1'b1, 3'd2, 8'd2);
    look("R9", 32'h2000, 1'b1, 3'd3, 8'd3);

    sendEv(3'd7, 32'h1050, 8'd0);               // R6 frees one entry
    look("R6", 32'h1050, 1'b0, 3'd0, 8'd0);
    sendEv(3'd3, 32'h3000, 8'd4);               // R8 uses free slot
    look("R8", 32'h3000, 1'b1, 3'd1, 8'd4);
    look("R8", 32'h1002, 1'b1, 3'd3, 8'd1);
    sendEv(3'd3, 32'h3001, 8'd5);               // R9 now evicts 0x1002
    look("R9", 32'h1002, 1'b0, 3'd0, 8'd0);

    sendEv(3'd6, 32'h1003, 8'd0);               // R5 stale
    look("R5", 32'h1003, 1'b0, 3'd4, 8'd0);
    sendEv(3'd3, 32'h1003, 8'd6);               // R5 reuse stale entry
    look("R5", 32'h1003, 1'b1, 3'd1, 8'd6);
    look("R5", 32'h1004, 1'b1, 3'd3, 8'd1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule